// File: doc/BRIEF.md
# Staged Configuration Register Writer

This block keeps one 32-bit configuration word and lets a host rewrite it over either of two access paths. On the parallel path the host drives a 16-bit data bus, an active-low select and a write strobe. In 16-bit mode two strobes make a full update. In 8-bit mode four strobes make a full update, with the byte carried on the upper half of the bus. On the serial path the host lowers a frame signal and clocks 32 bits in, most significant bit first. The word that arrives decides whether the whole register or only its top byte is rewritten.

Every access first rewrites the top byte, bits 31:24, straight away. The rest of a parallel sequence is held in a staging store and is only applied, all at once, by the closing strobe of the sequence. If the select is released early, the staged bytes are lost. All path inputs are sampled on the block clock. A strobe rising edge or a serial-clock falling edge is recognised in the cycle in which the new level is first sampled, and the register shows the result one clock later.

Top module: `cfgw_stager`

## Requirements
- R1: While `rst` is high at a clock edge, the register is loaded with all zeros, and any partial sequence in progress is abandoned.
- R2: In 16-bit mode (`byte_mode`=0, `ser_mode`=0), the first strobe rising edge after `cs_n` falls copies `par_din[15:8]` into bits 31:24 and leaves bits 23:0 unchanged.
- R3: In 16-bit mode, the second strobe with `cs_n` still low writes bits 23:16 with the `par_din[7:0]` value held from the first strobe, and bits 15:0 with the current `par_din[15:0]`.
- R4: In 8-bit mode (`byte_mode`=1), the byte is `par_din[15:8]`. The first strobe writes bits 31:24. The second and third strobes only stage their bytes. The fourth strobe writes bits 23:16, 15:8 and 7:0 with the second, third and fourth bytes.
- R5: Raising `cs_n` before a sequence completes discards the staged bytes, and the next strobe after `cs_n` falls again acts as a first strobe.
- R6: The register changes only one clock after a sampled low-to-high change of `wr_stb` with `cs_n` low. A strobe held high, or any strobe while `cs_n` is high, has no effect.
- R7: In serial mode (`ser_mode`=1) with `frame_n` low, `sdi` is taken on each sampled high-to-low change of `sclk`, most significant bit first. On the 32nd such change, if bit 16 of the received word is 1, the whole register is replaced one clock later.
- R8: If bit 16 of the received 32-bit word is 0, only bits 31:24 take the received value, and bits 23:0 are kept.
- R9: Raising `frame_n` before the 32nd bit abandons the serial access with no change to the register, and the next access starts counting from its first bit again.
- R10: With `ser_mode`=1 the parallel pins have no effect, and with `ser_mode`=0 the serial pins have no effect.
- R11: After a completed 16-bit or 8-bit sequence, a further strobe with `cs_n` still low starts a new sequence, and that strobe updates only bits 31:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_mode | input | 1 | 1 selects the serial path, 0 selects the parallel path |
| byte_mode | input | 1 | Parallel width: 0 is 16-bit beats, 1 is 8-bit beats on par_din[15:8] |
| cs_n | input | 1 | Active-low parallel select; a high level ends a sequence |
| wr_stb | input | 1 | Parallel write strobe; acts on its rising edge |
| par_din | input | 16 | Parallel write data |
| frame_n | input | 1 | Active-low serial frame; a high level ends an access |
| sclk | input | 1 | Serial bit clock; bits are taken on its falling edge |
| sdi | input | 1 | Serial data in, MSB first |
| cfg_word | output | 32 | Current configuration word |

## Verification
The checks assume that every path input is synchronous to `clk`. They also assume that each phase of `wr_stb` and `sclk` lasts at least one clock, so that every edge is seen exactly once. A further assumption is that `ser_mode` and `byte_mode` are held steady for the whole of an access. The stimulus changes every input one nanosecond after a rising clock edge and holds each strobe and serial-clock phase for one or two full cycles. It changes the mode pins only while `cs_n` and `frame_n` are both high, so no sequence ever straddles a mode change.

// File: rtl/cfgw_pkg.sv
`timescale 1ns/1ps
package cfgw_pkg;
    localparam int CFG_W      = 32;
    localparam int BUS_W      = 16;
    localparam int LANE_W     = 8;
    localparam int HI_W       = LANE_W;
    localparam int LO_W       = CFG_W - HI_W;
    localparam int STAGE_W    = LO_W - LANE_W;
    localparam int FULL_BIT   = 16;
    localparam int BYTE_BEATS = CFG_W / LANE_W;
    localparam int BEAT_W     = $clog2(BYTE_BEATS);
    localparam int SCNT_W     = $clog2(CFG_W);

    typedef logic [CFG_W-1:0] cfg_word_t;

    typedef struct packed {
        logic            hi_we;
        logic            lo_we;
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } cfg_upd_t;

    localparam cfg_upd_t NO_UPD = '0;

    function automatic cfg_word_t apply_upd(cfg_word_t cur, cfg_upd_t u);
        cfg_word_t nxt;
        nxt = cur;
        if (u.hi_we) nxt[CFG_W-1 -: HI_W] = u.hi;
        if (u.lo_we) nxt[LO_W-1:0] = u.lo;
        return nxt;
    endfunction
endpackage

// File: rtl/cfgw_edge.sv
`timescale 1ns/1ps
module cfgw_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        prev_q <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign rise[i] = lvl[i] & ~prev_q[i];
        assign fall[i] = ~lvl[i] & prev_q[i];
    end
endmodule

// File: rtl/cfgw_par_path.sv
`timescale 1ns/1ps
module cfgw_par_path
    import cfgw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             cs_n,
    input  logic             wr_rise,
    input  logic             byte_mode,
    input  logic [BUS_W-1:0] din,
    output cfg_upd_t         upd
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BYTE_BEATS - 1);

    logic [BEAT_W-1:0]  beat_q;
    logic [STAGE_W-1:0] stage_q;
    logic [LANE_W-1:0]  lane_hi;
    logic [LANE_W-1:0]  lane_lo;
    logic               fire;

    assign lane_hi = din[BUS_W-1 -: LANE_W];
    assign lane_lo = din[LANE_W-1:0];
    assign fire    = enable && !cs_n && wr_rise;

    always_comb begin
        upd = NO_UPD;
        if (fire) begin
            if (beat_q == '0) begin
                upd.hi_we = 1'b1;
                upd.hi    = lane_hi;
            end else if (!byte_mode) begin
                upd.lo_we = 1'b1;
                upd.lo    = {stage_q[STAGE_W-1 -: LANE_W], din};
            end else if (beat_q == LAST_BEAT) begin
                upd.lo_we = 1'b1;
                upd.lo    = {stage_q, lane_hi};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable || cs_n) begin
            beat_q  <= '0;
            stage_q <= '0;
        end else if (fire) begin
            if (beat_q == '0) begin
                beat_q <= BEAT_W'(1);
                if (!byte_mode) stage_q[STAGE_W-1 -: LANE_W] <= lane_lo;
            end else if (!byte_mode || beat_q == LAST_BEAT) begin
                beat_q <= '0;
            end else begin
                stage_q <= {stage_q[LANE_W-1:0], lane_hi};
                beat_q  <= beat_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfgw_ser_path.sv
`timescale 1ns/1ps
module cfgw_ser_path
    import cfgw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     frame_n,
    input  logic     sclk_fall,
    input  logic     sdi,
    output cfg_upd_t upd
);
    logic [SCNT_W-1:0] cnt_q;
    logic [CFG_W-2:0]  shift_q;
    cfg_word_t         incoming;
    logic              fire;
    logic              last_bit;

    assign incoming = {shift_q, sdi};
    assign fire     = enable && !frame_n && sclk_fall;
    assign last_bit = (cnt_q == SCNT_W'(CFG_W - 1));

    always_comb begin
        upd = NO_UPD;
        if (fire && last_bit) begin
            upd.hi_we = 1'b1;
            upd.hi    = incoming[CFG_W-1 -: HI_W];
            upd.lo_we = incoming[FULL_BIT];
            upd.lo    = incoming[LO_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable || frame_n) begin
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (fire) begin
            shift_q <= incoming[CFG_W-2:0];
            cnt_q   <= last_bit ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cfgw_stager.sv
`timescale 1ns/1ps
module cfgw_stager
    import cfgw_pkg::*;
#(
    parameter logic [31:0] RESET_VALUE = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_mode,
    input  logic        byte_mode,
    input  logic        cs_n,
    input  logic        wr_stb,
    input  logic [15:0] par_din,
    input  logic        frame_n,
    input  logic        sclk,
    input  logic        sdi,
    output logic [31:0] cfg_word
);
    localparam int EDGE_N = 2;

    logic [EDGE_N-1:0] edge_rise;
    logic [EDGE_N-1:0] edge_fall;
    cfg_upd_t          par_upd;
    cfg_upd_t          ser_upd;
    cfg_word_t         cfg_q;

    cfgw_edge #(.N(EDGE_N)) u_edge (
        .clk  (clk),
        .lvl  ({sclk, wr_stb}),
        .rise (edge_rise),
        .fall (edge_fall)
    );

    cfgw_par_path u_par (
        .clk       (clk),
        .rst       (rst),
        .enable    (!ser_mode),
        .cs_n      (cs_n),
        .wr_rise   (edge_rise[0]),
        .byte_mode (byte_mode),
        .din       (par_din),
        .upd       (par_upd)
    );

    cfgw_ser_path u_ser (
        .clk       (clk),
        .rst       (rst),
        .enable    (ser_mode),
        .frame_n   (frame_n),
        .sclk_fall (edge_fall[1]),
        .sdi       (sdi),
        .upd       (ser_upd)
    );

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= RESET_VALUE;
        else     cfg_q <= apply_upd(apply_upd(cfg_q, par_upd), ser_upd);
    end

    assign cfg_word = cfg_q;
endmodule

// File: rtl/cfgw_checker.sv
`timescale 1ns/1ps
module cfgw_checker (
    input logic        clk,
    input logic        rst,
    input logic        ser_mode,
    input logic        cs_n,
    input logic        wr_stb,
    input logic        frame_n,
    input logic        sclk,
    input logic [31:0] cfg_word
);
    // R1: reset loads all zeros
    a_r1_reset_zero: assert property (@(posedge clk) rst |=> cfg_word == 32'h0);

    // R6: no sampled strobe edge and no serial edge means no change
    a_r6_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!(!ser_mode && !cs_n && $rose(wr_stb)) && !(ser_mode && !frame_n && $fell(sclk)))
        |=> $stable(cfg_word));

    // R6: parallel select high blocks every parallel write
    a_r6_cs_high_stable: assert property (@(posedge clk) disable iff (rst)
        (!ser_mode && cs_n) |=> $stable(cfg_word));

    // R10: in serial mode only a serial clock fall can change the word
    a_r10_ser_ignores_par: assert property (@(posedge clk) disable iff (rst)
        (ser_mode && !$fell(sclk)) |=> $stable(cfg_word));

    // R9: serial frame high blocks every serial update
    a_r9_frame_high_stable: assert property (@(posedge clk) disable iff (rst)
        (ser_mode && frame_n) |=> $stable(cfg_word));
endmodule

bind cfgw_stager cfgw_checker u_cfgw_checker (
    .clk      (clk),
    .rst      (rst),
    .ser_mode (ser_mode),
    .cs_n     (cs_n),
    .wr_stb   (wr_stb),
    .frame_n  (frame_n),
    .sclk     (sclk),
    .cfg_word (cfg_word)
);

// File: tb/cfgw_stager_bench.sv
`timescale 1ns/1ps
module cfgw_stager_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_mode = 1'b0;
    logic        byte_mode = 1'b0;
    logic        cs_n = 1'b1;
    logic        wr_stb = 1'b0;
    logic [15:0] par_din = 16'h0;
    logic        frame_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdi = 1'b0;
    logic [31:0] cfg_word;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    cfgw_stager u_cfgw_stager (
        .clk       (clk),
        .rst       (rst),
        .ser_mode  (ser_mode),
        .byte_mode (byte_mode),
        .cs_n      (cs_n),
        .wr_stb    (wr_stb),
        .par_din   (par_din),
        .frame_n   (frame_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .cfg_word  (cfg_word)
    );

    // Behavioural reference model
    logic [31:0] m_cfg = 32'h0;
    logic [31:0] m_shift = 32'h0;
    logic [7:0]  m_stage[$];
    int          m_beat = 0;
    int          m_bits = 0;
    logic        p_wstb = 1'b0;
    logic        p_sclk = 1'b1;

    always @(posedge clk) begin
        logic wr_edge, sc_edge;
        logic [7:0] b;
        wr_edge = wr_stb && !p_wstb;
        sc_edge = !sclk && p_sclk;
        if (rst) begin
            m_cfg = 32'h0; m_beat = 0; m_bits = 0; m_stage.delete();
        end else if (!ser_mode) begin
            m_bits = 0;
            if (cs_n) begin
                m_beat = 0; m_stage.delete();
            end else if (wr_edge) begin
                if (!byte_mode) begin
                    if (m_beat == 0) begin
                        m_cfg[31:24] = par_din[15:8];
                        m_stage.delete(); m_stage.push_back(par_din[7:0]); m_beat = 1;
                    end else begin
                        m_cfg[23:0] = {m_stage[0], par_din};
                        m_stage.delete(); m_beat = 0;
                    end
                end else begin
                    b = par_din[15:8];
                    if (m_beat == 0) begin
                        m_cfg[31:24] = b; m_stage.delete();
                    end else if (m_beat < 3) begin
                        m_stage.push_back(b);
                    end else begin
                        m_cfg[23:0] = {m_stage[0], m_stage[1], b}; m_stage.delete();
                    end
                    m_beat = (m_beat + 1) % 4;
                end
            end
        end else begin
            m_beat = 0; m_stage.delete();
            if (frame_n) begin
                m_bits = 0;
            end else if (sc_edge) begin
                m_shift = {m_shift[30:0], sdi};
                m_bits++;
                if (m_bits == 32) begin
                    if (m_shift[16]) m_cfg = m_shift;
                    else             m_cfg[31:24] = m_shift[31:24];
                    m_bits = 0;
                end
            end
        end
        p_wstb = wr_stb;
        p_sclk = sclk;
    end

    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (cfg_word !== m_cfg) begin
                miscompares++;
                $display("FAIL %s: cfg_word=%h expected %h", cur_req, cfg_word, m_cfg);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic pwrite(input logic [15:0] d);
        par_din = d; wr_stb = 1'b1; tick(2);
        wr_stb = 1'b0; tick(2);
    endtask

    task automatic saccess(input logic [31:0] w, input int nbits);
        frame_n = 1'b0; tick(1);
        for (int i = 31; i >= 32 - nbits; i--) begin
            sdi = w[i]; sclk = 1'b0; tick(1);
            sclk = 1'b1; tick(1);
        end
        frame_n = 1'b1; tick(2);
    endtask

    task automatic expect_word(input string req, input logic [31:0] exp);
        vectors++;
        if (cfg_word !== exp) begin
            miscompares++;
            $display("FAIL %s: cfg_word=%h expected %h", req, cfg_word, exp);
        end
    endtask

    initial begin
        tick(3);
        expect_word("R1", 32'h0);
        rst = 1'b0; tick(2);

        cur_req = "R2"; cs_n = 1'b0; tick(1);
        pwrite(16'hA1B2);
        expect_word("R2", 32'hA100_0000);
        cur_req = "R3"; pwrite(16'hC3D4); cs_n = 1'b1; tick(1);
        expect_word("R3", 32'hA1B2_C3D4);

        cur_req = "R5"; cs_n = 1'b0; tick(1);
        pwrite(16'h5E77); cs_n = 1'b1; tick(2);
        cs_n = 1'b0; tick(1);
        pwrite(16'h9911); cs_n = 1'b1; tick(1);
        expect_word("R5", 32'h99B2_C3D4);

        cur_req = "R6"; wr_stb = 1'b1; par_din = 16'hFFFF; tick(3);
        wr_stb = 1'b0; tick(1);
        expect_word("R6", 32'h99B2_C3D4);

        cur_req = "R4"; byte_mode = 1'b1; cs_n = 1'b0; tick(1);
        pwrite(16'h12EE); pwrite(16'h34EE); pwrite(16'h56EE); pwrite(16'h78EE);
        expect_word("R4", 32'h1234_5678);
        cur_req = "R11"; pwrite(16'h4400);
        expect_word("R11", 32'h4434_5678);
        cs_n = 1'b1; tick(1);

        cur_req = "R5"; cs_n = 1'b0; tick(1);
        pwrite(16'hAA00); pwrite(16'hBB00); cs_n = 1'b1; tick(2);
        cs_n = 1'b0; tick(1);
        pwrite(16'hCC00); pwrite(16'hDD00); pwrite(16'hEE00); pwrite(16'hF000);
        cs_n = 1'b1; tick(1);
        expect_word("R5", 32'hCCDD_EEF0);
        byte_mode = 1'b0; tick(1);

        cur_req = "R11"; cs_n = 1'b0; tick(1);
        pwrite(16'h0102); pwrite(16'h0304); pwrite(16'h0506);
        cs_n = 1'b1; tick(1);
        expect_word("R11", 32'h0502_0304);

        cur_req = "R7"; ser_mode = 1'b1; tick(1);
        saccess(32'hDEAD_BEEF, 32);
        expect_word("R7", 32'hDEAD_BEEF);
        cur_req = "R8"; saccess(32'h1234_0000, 32);
        expect_word("R8", 32'h12AD_BEEF);

        cur_req = "R9"; saccess(32'hFFFF_FFFF, 20);
        expect_word("R9", 32'h12AD_BEEF);
        saccess(32'h0F0F_5A5A, 32);
        expect_word("R9", 32'h0F0F_5A5A);

        cur_req = "R10"; cs_n = 1'b0; tick(1);
        pwrite(16'hFFFF); pwrite(16'hFFFF); cs_n = 1'b1; tick(1);
        expect_word("R10", 32'h0F0F_5A5A);
        ser_mode = 1'b0; tick(1);
        saccess(32'h8001_0001, 32);
        expect_word("R10", 32'h0F0F_5A5A);

        cur_req = "R1"; cs_n = 1'b0; tick(1); pwrite(16'h7700);
        rst = 1'b1; tick(2); rst = 1'b0; cs_n = 1'b1; tick(1);
        expect_word("R1", 32'h0);
        tick(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog during %s: run did not end, expected completion", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule